// File: doc/BRIEF.md
# Multi-Client Memory Request Arbiter

This block lets several client modules share one burst-oriented memory port. A client raises its request line and waits. The arbiter first grants it a three-cycle command phase. In that phase the client places the target address, then the burst length, then the direction on a shared info bus. The arbiter stores the command in a small queue for that client. Later it gives the client a data grant, and the burst moves over the shared data path during that grant.

The arbiter picks the next burst only from the oldest pending command of each client, so one client's commands never overtake each other. Across clients it reorders to keep the data path busy. A command that targets the row already open in its bank comes before one that does not. Among row hits, one that keeps the previous transfer direction comes first. Each waiting command counts how often it has been passed over. Once that count reaches a limit, the command is served next, so no client waits forever. The memory side is a plain port: a start pulse with the command fields, then one beat each cycle the memory signals ready.

Top module: `mreq_arbiter`

## Requirements
- R1: A command grant goes to at most one client, lasts exactly three consecutive cycles and is followed by at least one cycle with no command grant. In the first grant cycle the info bus carries the address. In the second cycle its low LEN_W bits carry the burst length, coded as beats minus one. In the third cycle bit 0 carries the direction (1 = write, 0 = read).
- R2: A command grant goes only to a client whose request is high and which holds fewer than SLOTS commands that have not yet started a burst.
- R3: The address is split as {row, bank, column}, with the column in the least significant bits. These fields appear unchanged on memRow, memBank and memCol for the whole burst.
- R4: The bursts of any one client start in the order in which that client issued its commands.
- R5: At most one data grant is high at a time. It rises in the first cycle of a burst, stays on the same client until the last beat completes, and no other burst starts while one is active.
- R6: When a burst is chosen, the ranking is: a row hit in the same direction as the previous burst, then a row hit, then more times passed over. Remaining ties go round-robin, starting at the client after the last one served.
- R7: Each bank keeps one open row, set by the last burst started in that bank. After reset no bank has an open row, so nothing counts as a hit.
- R8: Each time another client's burst starts while a client's head command waits, the head's pass-over count rises by one, saturating at MAX_BYPASS. The count restarts at zero for the next command. A head whose count has reached MAX_BYPASS outranks every non-forced head.
- R9: memStart is high for exactly the first cycle of a burst. memActive stays high until the beat count given by memBurstLen+1 has completed. A beat completes on each cycle in which memBeatReady is high.
- R10: During a write burst memWrData equals the shared wrData bus. During a read burst rdData equals memRdData, and rdValid is high exactly on cycles in which a read beat completes.
- R11: After reset all grants, memActive, memStart and rdValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | NUM_CLIENTS | Request line per client |
| grantCmd | output | NUM_CLIENTS | Command-phase grant per client |
| grantData | output | NUM_CLIENTS | Data-phase grant per client |
| infoBus | input | ROW_W+BANK_W+COL_W | Shared command info bus |
| wrData | input | DATA_W | Shared write data from the granted client |
| rdData | output | DATA_W | Read data to the granted client |
| rdValid | output | 1 | Read beat valid |
| memActive | output | 1 | Burst in progress on the memory port |
| memStart | output | 1 | First cycle of a burst |
| memWrite | output | 1 | Burst direction, 1 = write |
| memRow | output | ROW_W | Row of the active burst |
| memBank | output | BANK_W | Bank of the active burst |
| memCol | output | COL_W | Start column of the active burst |
| memBurstLen | output | LEN_W | Beats minus one |
| memWrData | output | DATA_W | Write data to memory |
| memRdData | input | DATA_W | Read data from memory |
| memBeatReady | input | 1 | Memory completes a beat this cycle |

## Verification
The bench uses three clients, two command slots each, four banks and MAX_BYPASS of 2. With two slots, a client can hold a second command that competes with the others. With a limit of 2, forced service appears after only a few selections. Holding the memory stalled during a long first burst lets all commands queue up. Directed scenarios then fix the exact order of service for the row-hit and direction ranking, for forced service of a passed-over client, and for the empty open-row state after reset. A long random run with irregular memory stalls checks per-client order, the command fields and the data passed on every beat.

// File: rtl/mreq_pkg.sv
package mreq_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE,
    CMD_ADDR,
    CMD_LEN,
    CMD_OP
  } cmdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capAddr;     // latch address from the info bus
    logic capLen;      // latch burst length from the info bus
    logic pushOp;      // latch direction and push the command
    logic startBurst;  // pop the selected head into the active registers
    logic beatDone;    // one beat completed on the memory port
  } strobes_t;

  localparam int RANK_W = 2;

endpackage

// File: rtl/mreq_dpath.sv
module mreq_dpath
  import mreq_pkg::*;
#(
  parameter int NUM_CLIENTS = 3,
  parameter int CID_W       = 2,
  parameter int ROW_W       = 4,
  parameter int BANK_W      = 2,
  parameter int COL_W       = 4,
  parameter int LEN_W       = 2,
  parameter int DATA_W      = 16,
  parameter int SLOTS       = 2,
  parameter int AGE_W       = 2,
  parameter int MAX_BYPASS  = 2
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  strobes_t                             strb,
  input  logic [CID_W-1:0]                     cmdClient,
  input  logic [CID_W-1:0]                     selClient,
  input  logic [ROW_W+BANK_W+COL_W-1:0]        infoBus,
  input  logic [DATA_W-1:0]                    wrData,
  input  logic [DATA_W-1:0]                    memRdData,
  output logic [NUM_CLIENTS-1:0]               headValid,
  output logic [NUM_CLIENTS-1:0]               slotFree,
  output logic [NUM_CLIENTS-1:0]               headHit,
  output logic [NUM_CLIENTS-1:0]               headSameDir,
  output logic [NUM_CLIENTS-1:0][AGE_W-1:0]    headAge,
  output logic                                 lastBeat,
  output logic                                 memWrite,
  output logic [ROW_W-1:0]                     memRow,
  output logic [BANK_W-1:0]                    memBank,
  output logic [COL_W-1:0]                     memCol,
  output logic [LEN_W-1:0]                     memBurstLen,
  output logic [DATA_W-1:0]                    memWrData,
  output logic [DATA_W-1:0]                    rdData
);

  localparam int ADDR_W    = ROW_W + BANK_W + COL_W;
  localparam int ENT_W     = ADDR_W + LEN_W + 1;
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int PTR_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CNT_W     = $clog2(SLOTS + 1);

  // command capture
  logic [ADDR_W-1:0] capAddrQ;
  logic [LEN_W-1:0]  capLenQ;
  logic [ENT_W-1:0]  newEntry;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capAddrQ <= '0;
      capLenQ  <= '0;
    end else begin
      if (strb.capAddr) capAddrQ <= infoBus;
      if (strb.capLen)  capLenQ  <= infoBus[LEN_W-1:0];
    end
  end

  assign newEntry = {capAddrQ, capLenQ, infoBus[0]};

  // open-row tracking
  logic [ROW_W-1:0]     openRow [NUM_BANKS];
  logic [NUM_BANKS-1:0] openValid;
  logic                 lastWr, lastValid;

  logic [ENT_W-1:0] headEnt [NUM_CLIENTS];
  logic [ENT_W-1:0] selEnt;
  logic [ROW_W-1:0] selRow;
  logic [BANK_W-1:0] selBank;

  assign selEnt  = headEnt[selClient];
  assign selRow  = selEnt[ENT_W-1 -: ROW_W];
  assign selBank = selEnt[ENT_W-1-ROW_W -: BANK_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openValid <= '0;
      lastWr    <= 1'b0;
      lastValid <= 1'b0;
    end else if (strb.startBurst) begin
      openValid[selBank] <= 1'b1;
      lastWr             <= selEnt[0];
      lastValid          <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.startBurst) openRow[selBank] <= selRow;
  end

  // per-client command queues
  for (genvar c = 0; c < NUM_CLIENTS; c++) begin : gClient
    logic [ENT_W-1:0]  slotMem [SLOTS];
    logic [PTR_W-1:0]  rdPtr, wrPtr;
    logic [CNT_W-1:0]  cnt;
    logic [AGE_W-1:0]  age;
    logic              doPush, doPop;
    logic [ROW_W-1:0]  hRow;
    logic [BANK_W-1:0] hBank;

    assign doPush = strb.pushOp && (cmdClient == CID_W'(c));
    assign doPop  = strb.startBurst && (selClient == CID_W'(c));

    always_ff @(posedge clk) begin
      if (doPush) slotMem[wrPtr] <= newEntry;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdPtr <= '0;
        wrPtr <= '0;
        cnt   <= '0;
        age   <= '0;
      end else begin
        if (doPush) wrPtr <= (wrPtr == PTR_W'(SLOTS - 1)) ? '0 : wrPtr + 1'b1;
        if (doPop)  rdPtr <= (rdPtr == PTR_W'(SLOTS - 1)) ? '0 : rdPtr + 1'b1;
        if (doPush && !doPop)      cnt <= cnt + 1'b1;
        else if (doPop && !doPush) cnt <= cnt - 1'b1;
        // pass-over counting on the waiting head
        if (doPop)
          age <= '0;
        else if (strb.startBurst && (cnt != '0) && (age != AGE_W'(MAX_BYPASS)))
          age <= age + 1'b1;
      end
    end

    assign headEnt[c]     = slotMem[rdPtr];
    assign headValid[c]   = (cnt != '0);
    assign slotFree[c]    = (cnt < CNT_W'(SLOTS));
    assign headAge[c]     = age;
    assign hRow           = headEnt[c][ENT_W-1 -: ROW_W];
    assign hBank          = headEnt[c][ENT_W-1-ROW_W -: BANK_W];
    assign headHit[c]     = openValid[hBank] && (openRow[hBank] == hRow);
    assign headSameDir[c] = lastValid && (headEnt[c][0] == lastWr);

    // R2: a push never lands on a full queue
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
      doPush |-> (cnt < CNT_W'(SLOTS)) || doPop);
  end

  // active burst registers
  logic [ADDR_W-1:0] actAddr;
  logic [LEN_W-1:0]  actLen;
  logic              actWr;
  logic [LEN_W-1:0]  beatCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actAddr <= '0;
      actLen  <= '0;
      actWr   <= 1'b0;
      beatCnt <= '0;
    end else if (strb.startBurst) begin
      actAddr <= selEnt[ENT_W-1 -: ADDR_W];
      actLen  <= selEnt[LEN_W:1];
      actWr   <= selEnt[0];
      beatCnt <= '0;
    end else if (strb.beatDone && !lastBeat) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  assign lastBeat    = (beatCnt == actLen);
  assign memWrite    = actWr;
  assign memRow      = actAddr[ADDR_W-1 -: ROW_W];
  assign memBank     = actAddr[COL_W +: BANK_W];
  assign memCol      = actAddr[COL_W-1:0];
  assign memBurstLen = actLen;
  assign memWrData   = wrData;
  assign rdData      = memRdData;

endmodule

// File: rtl/mreq_ctrl.sv
module mreq_ctrl
  import mreq_pkg::*;
#(
  parameter int NUM_CLIENTS = 3,
  parameter int CID_W       = 2,
  parameter int AGE_W       = 2,
  parameter int MAX_BYPASS  = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_CLIENTS-1:0]            req,
  input  logic [NUM_CLIENTS-1:0]            headValid,
  input  logic [NUM_CLIENTS-1:0]            slotFree,
  input  logic [NUM_CLIENTS-1:0]            headHit,
  input  logic [NUM_CLIENTS-1:0]            headSameDir,
  input  logic [NUM_CLIENTS-1:0][AGE_W-1:0] headAge,
  input  logic                              lastBeat,
  input  logic                              memBeatReady,
  output strobes_t                          strb,
  output logic [CID_W-1:0]                  cmdClient,
  output logic [CID_W-1:0]                  selClient,
  output logic [NUM_CLIENTS-1:0]            grantCmd,
  output logic [NUM_CLIENTS-1:0]            grantData,
  output logic                              memActive,
  output logic                              memStart
);

  localparam int SCORE_W = RANK_W + AGE_W;

  // ---------------- command phase ----------------
  cmdState_e         cmdState;
  logic [CID_W-1:0]  cmdClientQ, cmdRr, cmdPick;
  logic              cmdFound;

  always_comb begin
    cmdFound = 1'b0;
    cmdPick  = '0;
    for (int i = 0; i < NUM_CLIENTS; i++) begin
      if (!cmdFound && req[(int'(cmdRr) + i) % NUM_CLIENTS]
          && slotFree[(int'(cmdRr) + i) % NUM_CLIENTS]) begin
        cmdFound = 1'b1;
        cmdPick  = CID_W'((int'(cmdRr) + i) % NUM_CLIENTS);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdState   <= CMD_IDLE;
      cmdClientQ <= '0;
      cmdRr      <= '0;
    end else begin
      case (cmdState)
        CMD_IDLE: if (cmdFound) begin
          cmdState   <= CMD_ADDR;
          cmdClientQ <= cmdPick;
          cmdRr      <= (cmdPick == CID_W'(NUM_CLIENTS - 1)) ? '0 : cmdPick + 1'b1;
        end
        CMD_ADDR: cmdState <= CMD_LEN;
        CMD_LEN:  cmdState <= CMD_OP;
        default:  cmdState <= CMD_IDLE;
      endcase
    end
  end

  assign cmdClient = cmdClientQ;

  always_comb begin
    grantCmd = '0;
    if (cmdState != CMD_IDLE) grantCmd[cmdClientQ] = 1'b1;
  end

  // ---------------- data phase selection ----------------
  logic                      busyQ, firstQ;
  logic [CID_W-1:0]          curClientQ, dataRr, winner;
  logic                      anyHead;
  logic [NUM_CLIENTS-1:0]    forced;
  logic [NUM_CLIENTS-1:0][SCORE_W-1:0] score;
  logic [SCORE_W-1:0]        bestScore;

  always_comb begin
    for (int c = 0; c < NUM_CLIENTS; c++) begin
      forced[c] = (headAge[c] >= AGE_W'(MAX_BYPASS));
      if (forced[c])                         score[c] = {2'd3, headAge[c]};
      else if (headHit[c] && headSameDir[c]) score[c] = {2'd2, headAge[c]};
      else if (headHit[c])                   score[c] = {2'd1, headAge[c]};
      else                                   score[c] = {2'd0, headAge[c]};
    end
  end

  always_comb begin
    anyHead   = 1'b0;
    winner    = '0;
    bestScore = '0;
    for (int i = 0; i < NUM_CLIENTS; i++) begin
      if (headValid[(int'(dataRr) + i) % NUM_CLIENTS] &&
          (!anyHead || score[(int'(dataRr) + i) % NUM_CLIENTS] > bestScore)) begin
        anyHead   = 1'b1;
        winner    = CID_W'((int'(dataRr) + i) % NUM_CLIENTS);
        bestScore = score[(int'(dataRr) + i) % NUM_CLIENTS];
      end
    end
  end

  assign selClient = winner;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ      <= 1'b0;
      firstQ     <= 1'b0;
      curClientQ <= '0;
      dataRr     <= '0;
    end else if (!busyQ) begin
      if (anyHead) begin
        busyQ      <= 1'b1;
        firstQ     <= 1'b1;
        curClientQ <= winner;
        dataRr     <= (winner == CID_W'(NUM_CLIENTS - 1)) ? '0 : winner + 1'b1;
      end
    end else begin
      firstQ <= 1'b0;
      if (memBeatReady && lastBeat) busyQ <= 1'b0;
    end
  end

  always_comb begin
    grantData = '0;
    if (busyQ) grantData[curClientQ] = 1'b1;
  end

  assign memActive = busyQ;
  assign memStart  = busyQ && firstQ;

  always_comb begin
    strb            = '0;
    strb.capAddr    = (cmdState == CMD_ADDR);
    strb.capLen     = (cmdState == CMD_LEN);
    strb.pushOp     = (cmdState == CMD_OP);
    strb.startBurst = !busyQ && anyHead;
    strb.beatDone   = busyQ && memBeatReady;
  end

  // R1: a command grant never hops to another client without a gap
  assert_cmd_grant_R1: assert property (@(posedge clk) disable iff (!rstN)
    (grantCmd != '0) |=> (grantCmd == '0) || (grantCmd == $past(grantCmd)));

  // R5: the data grant holds on one client until the last beat completes
  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memActive && !(memBeatReady && lastBeat)) |=> (grantData == $past(grantData)));

  // R8: when any head is forced, the started burst belongs to a forced head
  assert_forced_first_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.startBurst && (forced & headValid) != '0) |-> forced[selClient]);

  // R9: the start marker lasts a single cycle
  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    memStart |=> !memStart);

endmodule

// File: rtl/mreq_arbiter.sv
module mreq_arbiter
  import mreq_pkg::*;
#(
  parameter int NUM_CLIENTS = 3,
  parameter int ROW_W       = 4,
  parameter int BANK_W      = 2,
  parameter int COL_W       = 4,
  parameter int LEN_W       = 2,
  parameter int DATA_W      = 16,
  parameter int SLOTS       = 2,
  parameter int MAX_BYPASS  = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_CLIENTS-1:0]          req,
  output logic [NUM_CLIENTS-1:0]          grantCmd,
  output logic [NUM_CLIENTS-1:0]          grantData,
  input  logic [ROW_W+BANK_W+COL_W-1:0]   infoBus,
  input  logic [DATA_W-1:0]               wrData,
  output logic [DATA_W-1:0]               rdData,
  output logic                            rdValid,
  output logic                            memActive,
  output logic                            memStart,
  output logic                            memWrite,
  output logic [ROW_W-1:0]                memRow,
  output logic [BANK_W-1:0]               memBank,
  output logic [COL_W-1:0]                memCol,
  output logic [LEN_W-1:0]                memBurstLen,
  output logic [DATA_W-1:0]               memWrData,
  input  logic [DATA_W-1:0]               memRdData,
  input  logic                            memBeatReady
);

  localparam int CID_W = (NUM_CLIENTS > 1) ? $clog2(NUM_CLIENTS) : 1;
  localparam int AGE_W = $clog2(MAX_BYPASS + 1);

  strobes_t                          strb;
  logic [CID_W-1:0]                  cmdClient, selClient;
  logic [NUM_CLIENTS-1:0]            headValid, slotFree, headHit, headSameDir;
  logic [NUM_CLIENTS-1:0][AGE_W-1:0] headAge;
  logic                              lastBeat;

  mreq_ctrl #(
    .NUM_CLIENTS(NUM_CLIENTS), .CID_W(CID_W), .AGE_W(AGE_W), .MAX_BYPASS(MAX_BYPASS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .req(req),
    .headValid(headValid), .slotFree(slotFree), .headHit(headHit),
    .headSameDir(headSameDir), .headAge(headAge), .lastBeat(lastBeat),
    .memBeatReady(memBeatReady), .strb(strb), .cmdClient(cmdClient),
    .selClient(selClient), .grantCmd(grantCmd), .grantData(grantData),
    .memActive(memActive), .memStart(memStart)
  );

  mreq_dpath #(
    .NUM_CLIENTS(NUM_CLIENTS), .CID_W(CID_W), .ROW_W(ROW_W), .BANK_W(BANK_W),
    .COL_W(COL_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .SLOTS(SLOTS),
    .AGE_W(AGE_W), .MAX_BYPASS(MAX_BYPASS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdClient(cmdClient),
    .selClient(selClient), .infoBus(infoBus), .wrData(wrData),
    .memRdData(memRdData), .headValid(headValid), .slotFree(slotFree),
    .headHit(headHit), .headSameDir(headSameDir), .headAge(headAge),
    .lastBeat(lastBeat), .memWrite(memWrite), .memRow(memRow),
    .memBank(memBank), .memCol(memCol), .memBurstLen(memBurstLen),
    .memWrData(memWrData), .rdData(rdData)
  );

  assign rdValid = memActive && !memWrite && memBeatReady;

endmodule

// File: tb/test_mreq_arbiter.sv
module test_mreq_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N      = 3;
  localparam int ROW_W  = 4;
  localparam int BANK_W = 2;
  localparam int COL_W  = 4;
  localparam int LEN_W  = 2;
  localparam int DATA_W = 16;
  localparam int SLOTS  = 2;
  localparam int MAXB   = 2;
  localparam int ADDR_W = ROW_W + BANK_W + COL_W;
  localparam int WATCHDOG = 20000;

  typedef struct {
    int client; int row; int bank; int col; int beats; bit wr; int tag;
  } item_t;

  logic clk = 0, rstN = 0;
  logic [N-1:0] req = '0;
  logic [N-1:0] grantCmd, grantData;
  logic [ADDR_W-1:0] infoBus = '0;
  logic [DATA_W-1:0] wrData = '0, rdData, memWrData, memRdData = '0;
  logic rdValid, memActive, memStart, memWrite, memBeatReady = 1'b0;
  logic [ROW_W-1:0] memRow;
  logic [BANK_W-1:0] memBank;
  logic [COL_W-1:0] memCol;
  logic [LEN_W-1:0] memBurstLen;

  mreq_arbiter #(
    .NUM_CLIENTS(N), .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W),
    .LEN_W(LEN_W), .DATA_W(DATA_W), .SLOTS(SLOTS), .MAX_BYPASS(MAXB)
  ) i_mreq_arbiter (
    .clk(clk), .rstN(rstN), .req(req), .grantCmd(grantCmd), .grantData(grantData),
    .infoBus(infoBus), .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .memActive(memActive), .memStart(memStart), .memWrite(memWrite),
    .memRow(memRow), .memBank(memBank), .memCol(memCol), .memBurstLen(memBurstLen),
    .memWrData(memWrData), .memRdData(memRdData), .memBeatReady(memBeatReady)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  item_t cmdQ[N][$];
  item_t expQ[N][$];
  int orderLog[$];
  bit stallAll = 1, stallPat = 0, inBurst = 0, justEnded = 0;
  int cmdBeat = 0, curBeat = 0, tagCnt = 0;
  item_t cur;

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int oneIdx(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [DATA_W-1:0] pat(int tag, int beat);
    return {tag[7:0], beat[7:0]};
  endfunction

  // driver side of clients and memory model, all at the falling edge
  always @(negedge clk) begin
    if (!rstN) begin
      cmdBeat = 0; infoBus = '0; memBeatReady = 1'b0; justEnded = 0;
    end else begin
      // memory monitor / scoreboard
      if (justEnded) chk(!memActive || memStart, "R9", "burst ran past its beats", 1, 0);
      justEnded = 0;
      if (memStart) begin
        int c;
        c = oneIdx(grantData);
        chk($countones(grantData) == 1, "R5", "data grants at start", $countones(grantData), 1);
        if (c >= 0 && expQ[c].size() != 0) begin
          cur = expQ[c].pop_front();
          orderLog.push_back(c);
          chk(memRow == cur.row[ROW_W-1:0], "R3", "row", memRow, cur.row);
          chk(memBank == cur.bank[BANK_W-1:0], "R3", "bank", memBank, cur.bank);
          chk(memCol == cur.col[COL_W-1:0], "R3", "col", memCol, cur.col);
          chk(memBurstLen == LEN_W'(cur.beats - 1), "R9", "burst length", memBurstLen, cur.beats - 1);
          chk(memWrite == cur.wr, "R4", "direction of next in-order item", memWrite, cur.wr);
        end else chk(0, "R4", "burst start with no pending item of client", c, -1);
        curBeat = 0; inBurst = 1;
      end else if (memActive) begin
        chk(inBurst, "R9", "active without a start", 1, 0);
      end
      memBeatReady = !stallAll && (!stallPat || ($urandom_range(0, 3) != 0));
      if (inBurst) begin
        wrData    = pat(cur.tag, curBeat);
        memRdData = ~pat(cur.tag, curBeat);
      end
      // command driver
      if (grantCmd != '0) begin
        int c;
        c = oneIdx(grantCmd);
        chk($countones(grantCmd) == 1, "R1", "command grants", $countones(grantCmd), 1);
        chk(cmdBeat < 3, "R1", "command grant length", cmdBeat + 1, 3);
        if (cmdQ[c].size() == 0) begin
          chk(0, "R2", "grant to a client with no request", c, -1);
        end else begin
          item_t it;
          it = cmdQ[c][0];
          if (cmdBeat == 0) begin
            chk(expQ[c].size() < SLOTS, "R2", "pending slots at grant", expQ[c].size(), SLOTS - 1);
            infoBus = {it.row[ROW_W-1:0], it.bank[BANK_W-1:0], it.col[COL_W-1:0]};
          end else if (cmdBeat == 1) begin
            infoBus = ADDR_W'(it.beats - 1);
          end else if (cmdBeat == 2) begin
            infoBus = ADDR_W'(it.wr);
            expQ[c].push_back(it);
            void'(cmdQ[c].pop_front());
          end
        end
        cmdBeat++;
      end else begin
        if (cmdBeat != 0) chk(cmdBeat == 3, "R1", "command grant length", cmdBeat, 3);
        cmdBeat = 0;
      end
      for (int c = 0; c < N; c++) req[c] = (cmdQ[c].size() != 0);
      #1;
      if (inBurst) begin
        chk(grantData == N'(1 << cur.client), "R5", "data grant owner", grantData, 1 << cur.client);
        chk(memActive, "R9", "memActive during burst", memActive, 1);
        if (cur.wr) chk(memWrData == wrData, "R10", "write data", memWrData, wrData);
        else begin
          chk(rdValid == memBeatReady, "R10", "read valid", rdValid, memBeatReady);
          chk(rdData == memRdData, "R10", "read data", rdData, memRdData);
        end
        if (memBeatReady) begin
          curBeat++;
          if (curBeat == cur.beats) begin inBurst = 0; justEnded = 1; end
        end
      end
    end
  end

  task automatic addReq(int c, int row, int bank, int col, int beats, bit wr);
    item_t it;
    it.client = c; it.row = row; it.bank = bank; it.col = col;
    it.beats = beats; it.wr = wr; it.tag = tagCnt++;
    cmdQ[c].push_back(it);
  endtask

  task automatic doReset();
    @(posedge clk);
    rstN <= 1'b0; stallAll = 1; stallPat = 0;
    for (int c = 0; c < N; c++) begin cmdQ[c].delete(); expQ[c].delete(); end
    orderLog.delete(); inBurst = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk(grantCmd == '0, "R11", "grantCmd after reset", grantCmd, 0);
    chk(grantData == '0, "R11", "grantData after reset", grantData, 0);
    chk(!memActive && !memStart && !rdValid, "R11", "memory port idle", memActive, 0);
    @(posedge clk); rstN <= 1'b1;
  endtask

  task automatic waitStarts(int n);
    while (orderLog.size() < n) @(posedge clk);
  endtask

  task automatic waitCmdsDone();
    bit busy;
    busy = 1;
    while (busy) begin
      @(posedge clk);
      busy = 0;
      for (int c = 0; c < N; c++) if (cmdQ[c].size() != 0) busy = 1;
    end
    repeat (4) @(posedge clk);
  endtask

  task automatic waitDrain();
    bit busy;
    busy = 1;
    while (busy) begin
      @(posedge clk);
      busy = inBurst;
      for (int c = 0; c < N; c++) if (cmdQ[c].size() != 0 || expQ[c].size() != 0) busy = 1;
    end
    repeat (3) @(posedge clk);
  endtask

  task automatic checkOrder(string rq, int exp[]);
    chk(orderLog.size() == exp.size(), rq, "bursts served", orderLog.size(), exp.size());
    for (int i = 0; i < exp.size() && i < orderLog.size(); i++)
      chk(orderLog[i] == exp[i], rq, $sformatf("client of burst %0d", i), orderLog[i], exp[i]);
  endtask

  initial begin
    // scenario A: R6 row hit and direction ranking
    doReset();
    addReq(0, 5, 0, 1, 4, 0);
    waitStarts(1);
    addReq(1, 7, 0, 2, 2, 0);
    addReq(2, 5, 0, 3, 3, 1);
    addReq(0, 5, 0, 4, 1, 0);
    waitCmdsDone();
    stallAll = 0;
    waitDrain();
    checkOrder("R6", '{0, 0, 2, 1});

    // scenario B: R8 forced service after MAX_BYPASS pass-overs
    doReset();
    addReq(0, 3, 1, 0, 4, 1);
    waitStarts(1);
    addReq(0, 3, 1, 1, 1, 1);
    addReq(0, 3, 1, 2, 1, 1);
    addReq(1, 9, 1, 3, 2, 1);
    addReq(2, 3, 1, 4, 1, 1);
    addReq(2, 3, 1, 5, 1, 1);
    waitCmdsDone();
    stallAll = 0;
    waitDrain();
    checkOrder("R8", '{0, 2, 0, 1, 2, 0});

    // scenario C: R7 no open row after reset
    doReset();
    addReq(0, 2, 3, 0, 2, 0);
    waitStarts(1);
    addReq(1, 5, 2, 0, 1, 0);
    addReq(2, 0, 0, 0, 1, 0);
    waitCmdsDone();
    stallAll = 0;
    waitDrain();
    checkOrder("R7", '{0, 1, 2});

    // scenario D: random traffic, R4 per-client order and R10 data
    doReset();
    stallAll = 0; stallPat = 1;
    for (int k = 0; k < 12; k++)
      for (int c = 0; c < N; c++)
        addReq(c, $urandom_range(1, 2), $urandom_range(0, 3), $urandom_range(0, 15),
               $urandom_range(1, 4), 1'($urandom_range(0, 1)));
    waitDrain();
    chk(orderLog.size() == 12 * N, "R4", "random bursts served", orderLog.size(), 12 * N);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    vectors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule